// File: doc/BRIEF.md
# Multi-Word GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller for a parameterised number of pins (102 by default). Pins are grouped 32 to a register word, and every kind of per-pin setting lives in its own bank of consecutive words. A plain synchronous bus carries the accesses: a byte address, a write strobe, write data and a combinational read-data return. On the pin side the block drives an output value and an output enable for each pin, and it takes a raw input level for each pin. The interrupt logic turns the input levels into latched status bits and merges them into a single interrupt line.

Every raw input goes through a two-flop synchronizer. An edge detector works on the synchronized level. A per-pin select bit chooses whether the rising or the falling edge counts. A pin can only raise its status bit when it is enabled and set to input. Software clears status bits by writing zeros. A per-pin mask bit stops a pending status bit from reaching the interrupt line. The enable bank and the edge-select bank are both optional. When the edge-select bank is left out, each status bit follows a high input level instead of an edge. Bit positions above the pin count in the last word hold no state.

Top module: `mwgpio_ctrl`

## Requirements
- R1: With the default sizing, byte address bits [6:4] pick the bank and bits [3:2] pick the word. Bank codes are: 0 pin enable, 1 output data, 2 direction, 3 input level, 4 interrupt mask, 5 status, 6 edge select. Pin n is bit n mod 32 of word n/32. An address with bits [1:0] not zero, or with bit 7 set, reads as zero and writes nothing. Bank 7 also reads as zero. A write takes effect at the next clock edge.
- R2: Synchronous reset clears every bank to zero, except direction, whose valid bits reset to one (input). While reset is held, irq and every pin_oe are 0.
- R3: pin_out[n] always carries the output-data bit of pin n. pin_oe[n] is 1 exactly when pin n is enabled and its direction bit is 0.
- R4: The input-level bank returns the synchronized pin levels. A change on pin_in shows up there after the second rising clock edge.
- R5: An edge-select bit of 1 counts rising edges and 0 counts falling edges. The other edge does nothing. The status bit is readable, and irq reflects it, after the third rising edge that follows the input change.
- R6: A status bit sets only when its pin is enabled and its direction bit is 1. Events on output pins or disabled pins leave status at zero.
- R7: Writing 0 to a status bit clears it, and writing 1 leaves it as it is. If an event and a clearing write hit the same bit at the same edge, the bit ends up set.
- R8: irq is 1 exactly when some status bit is 1 and its mask bit is 0. A mask bit of 1 blocks only the interrupt. The status bit stays readable.
- R9: Bits of the last word at or above the pin count read as zero in every bank. Writes to them have no effect, and they never report status.
- R10: Writes to the input-level bank are ignored.
- R11: Without the edge-select bank (HAS_EDGE = 0), a status bit sets on every edge where the synchronized level of an enabled input is high. So a clear written while the level is still high does not remove the bit. That bank reads as zero.
- R12: Without the enable bank (HAS_ENABLE = 0), every valid pin counts as enabled. The enable bank reads back as ones on the valid bits, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| pin_in | input | NUM_PINS | Raw asynchronous pin levels |
| pin_out | output | NUM_PINS | Output value of each pin |
| pin_oe | output | NUM_PINS | Output enable of each pin |
| irq | output | 1 | Combined interrupt, unmasked pending status |

## Verification
The results arrive at different times, and the checks sample each one in the cycle it is due:
- Read data depends only on the current address and the stored state, so it is sampled at the falling edge just after the address is set.
- A register write shows on bus_rdata, pin_out, pin_oe and irq at the falling edge after its rising edge.
- A pin change shows in the input-level bank after two rising edges.
- A pin change shows in status and on irq after three rising edges.

A behavioural model in the bench steps once per rising edge. At every falling edge the bench compares read data, both pin vectors and irq against that model. The directed checks also sample one cycle before each due edge, so that a result arriving early is reported as well as one arriving late. The set-wins case is timed so that the clearing write lands on exactly the edge where the event is recorded.

// File: rtl/mwgpio_pkg.sv
package mwgpio_pkg;

    localparam int PINS_PER_WORD = 32;

    typedef logic [PINS_PER_WORD-1:0] word_t;

    typedef enum logic [2:0] {
        BK_ENABLE = 3'd0,
        BK_DOUT   = 3'd1,
        BK_DIR    = 3'd2,
        BK_LEVEL  = 3'd3,
        BK_IMASK  = 3'd4,
        BK_STAT   = 3'd5,
        BK_EDGE   = 3'd6,
        BK_NONE   = 3'd7
    } bank_e;

    // Write request steered to one word slice.
    typedef struct packed {
        logic  wr;
        bank_e bank;
        word_t data;
    } wr_req_t;

    // Everything one word slice exposes to the read mux.
    typedef struct packed {
        word_t en;
        word_t dout;
        word_t dir;
        word_t lvl;
        word_t imask;
        word_t stat;
        word_t edge_rise;
    } word_view_t;

    function automatic int word_count(int pins);
        return (pins + PINS_PER_WORD - 1) / PINS_PER_WORD;
    endfunction

    function automatic int index_width(int words);
        return (words > 1) ? $clog2(words) : 1;
    endfunction

    function automatic int pins_in_word(int pins, int widx);
        int rest;
        rest = pins - widx * PINS_PER_WORD;
        return (rest >= PINS_PER_WORD) ? PINS_PER_WORD : rest;
    endfunction

    function automatic word_t low_ones(int n);
        word_t m;
        m = '0;
        for (int b = 0; b < PINS_PER_WORD; b++) begin
            if (b < n) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/mwgpio_sync_edge.sv
module mwgpio_sync_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] meta_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign level = lvl_q;
    assign rise  = lvl_q & ~prev_q;
    assign fall  = ~lvl_q & prev_q;

    AST_SYNC_TWO_STAGES: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (lvl_q == $past(raw, 2))); // R4

endmodule

// File: rtl/mwgpio_word.sv
module mwgpio_word
    import mwgpio_pkg::*;
#(
    parameter int CNT        = 32,
    parameter bit HAS_ENABLE = 1'b1,
    parameter bit HAS_EDGE   = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  wr_req_t        req,
    input  logic [CNT-1:0] pin_raw,
    output logic [CNT-1:0] pin_drv,
    output logic [CNT-1:0] pin_en_out,
    output word_view_t     view,
    output logic           irq_any
);

    localparam word_t VALID = low_ones(CNT);

    logic [CNT-1:0] lvl_n, rise_n, fall_n;
    word_t lvl_w, rise_w, fall_w;
    word_t en_q, dout_q, dir_q, imask_q, stat_q, edge_q;
    word_t en_eff, edge_eff, evt, hit, stat_keep;
    logic  wr_en, wr_dout, wr_dir, wr_mask, wr_stat, wr_edge;

    mwgpio_sync_edge #(.W(CNT)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (pin_raw),
        .level (lvl_n),
        .rise  (rise_n),
        .fall  (fall_n)
    );

    always_comb begin
        lvl_w  = '0;
        rise_w = '0;
        fall_w = '0;
        lvl_w[CNT-1:0]  = lvl_n;
        rise_w[CNT-1:0] = rise_n;
        fall_w[CNT-1:0] = fall_n;
    end

    assign wr_en   = req.wr && (req.bank == BK_ENABLE);
    assign wr_dout = req.wr && (req.bank == BK_DOUT);
    assign wr_dir  = req.wr && (req.bank == BK_DIR);
    assign wr_mask = req.wr && (req.bank == BK_IMASK);
    assign wr_stat = req.wr && (req.bank == BK_STAT);
    assign wr_edge = req.wr && (req.bank == BK_EDGE);

    // Optional banks: a missing bank behaves as fixed ones (enable) or fixed zeros (edge).
    assign en_eff   = HAS_ENABLE ? en_q : VALID;
    assign edge_eff = HAS_EDGE ? edge_q : '0;

    assign evt       = HAS_EDGE ? ((edge_eff & rise_w) | (~edge_eff & fall_w)) : lvl_w;
    assign hit       = evt & en_eff & dir_q & VALID;
    assign stat_keep = wr_stat ? (stat_q & req.data) : stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            dout_q  <= '0;
            dir_q   <= VALID;
            imask_q <= '0;
            stat_q  <= '0;
            edge_q  <= '0;
        end else begin
            if (wr_en)   en_q    <= req.data & VALID;
            if (wr_dout) dout_q  <= req.data & VALID;
            if (wr_dir)  dir_q   <= req.data & VALID;
            if (wr_mask) imask_q <= req.data & VALID;
            if (wr_edge) edge_q  <= req.data & VALID;
            stat_q <= stat_keep | hit;
        end
    end

    assign pin_drv    = dout_q[CNT-1:0];
    assign pin_en_out = en_eff[CNT-1:0] & ~dir_q[CNT-1:0];
    assign irq_any    = |(stat_q & ~imask_q);

    assign view.en        = en_eff;
    assign view.dout      = dout_q;
    assign view.dir       = dir_q;
    assign view.lvl       = lvl_w;
    assign view.imask     = imask_q;
    assign view.stat      = stat_q;
    assign view.edge_rise = edge_eff;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(hit)) == $past(hit))); // R7

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((dout_q | dir_q | imask_q | stat_q | en_eff | edge_eff) & ~VALID) == '0); // R9

    AST_STAT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~$past(stat_q)) & ~$past(en_eff & dir_q)) == '0); // R6

endmodule

// File: rtl/mwgpio_ctrl.sv
module mwgpio_ctrl
    import mwgpio_pkg::*;
#(
    parameter int NUM_PINS   = 102,
    parameter int ADDR_W     = 8,
    parameter bit HAS_ENABLE = 1'b1,
    parameter bit HAS_EDGE   = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    localparam int NUM_WORDS = word_count(NUM_PINS);
    localparam int WIDX_W    = index_width(NUM_WORDS);
    localparam int BANK_LSB  = WIDX_W + 2;
    localparam int BANK_MSB  = BANK_LSB + 2;

    logic              upper_zero;
    logic              addr_ok;
    bank_e             sel_bank;
    logic [WIDX_W-1:0] sel_word;
    word_view_t        views [NUM_WORDS];
    logic [NUM_WORDS-1:0] word_irq;

    generate
        if (ADDR_W > BANK_MSB + 1) begin : g_upper
            assign upper_zero = (bus_addr[ADDR_W-1:BANK_MSB+1] == '0);
        end else begin : g_no_upper
            assign upper_zero = 1'b1;
        end
    endgenerate

    assign addr_ok  = upper_zero && (bus_addr[1:0] == 2'b00);
    assign sel_bank = bank_e'(bus_addr[BANK_MSB:BANK_LSB]);
    assign sel_word = bus_addr[BANK_LSB-1:2];

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            localparam int LO  = w * PINS_PER_WORD;
            localparam int CNT = pins_in_word(NUM_PINS, w);
            wr_req_t rq;

            assign rq.wr   = bus_we && addr_ok && (sel_word == WIDX_W'(w));
            assign rq.bank = sel_bank;
            assign rq.data = bus_wdata;

            mwgpio_word #(
                .CNT        (CNT),
                .HAS_ENABLE (HAS_ENABLE),
                .HAS_EDGE   (HAS_EDGE)
            ) u_word (
                .clk        (clk),
                .rst        (rst),
                .req        (rq),
                .pin_raw    (pin_in[LO+CNT-1:LO]),
                .pin_drv    (pin_out[LO+CNT-1:LO]),
                .pin_en_out (pin_oe[LO+CNT-1:LO]),
                .view       (views[w]),
                .irq_any    (word_irq[w])
            );
        end
    endgenerate

    assign irq = |word_irq;

    always_comb begin
        bus_rdata = '0;
        if (addr_ok && (int'(sel_word) < NUM_WORDS)) begin
            case (sel_bank)
                BK_ENABLE: bus_rdata = views[sel_word].en;
                BK_DOUT:   bus_rdata = views[sel_word].dout;
                BK_DIR:    bus_rdata = views[sel_word].dir;
                BK_LEVEL:  bus_rdata = views[sel_word].lvl;
                BK_IMASK:  bus_rdata = views[sel_word].imask;
                BK_STAT:   bus_rdata = views[sel_word].stat;
                BK_EDGE:   bus_rdata = views[sel_word].edge_rise;
                default:   bus_rdata = '0;
            endcase
        end
    end

    AST_IRQ_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(bus_we)); // R8

    AST_RESET_NO_DRIVE: assert property (@(posedge clk)
        $past(rst) |-> (pin_oe == '0 && !irq)); // R2

endmodule

// File: tb/mwgpio_ctrl_test.sv
module mwgpio_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 102;
    localparam int NP2 = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic [7:0]    addr;
    logic          we;
    logic [31:0]   wdata;
    logic [NP-1:0] pin_in;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    logic [7:0]     addr2;
    logic           we2;
    logic [31:0]    wdata2;
    logic [NP2-1:0] pin_in2;
    logic [31:0]    rdata2;
    logic [NP2-1:0] pin_out2, pin_oe2;
    logic           irq2;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mwgpio_ctrl #(.NUM_PINS(NP), .ADDR_W(8), .HAS_ENABLE(1'b1), .HAS_EDGE(1'b1)) uut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    mwgpio_ctrl #(.NUM_PINS(NP2), .ADDR_W(8), .HAS_ENABLE(1'b0), .HAS_EDGE(1'b0)) uut_lvl (
        .clk(clk), .rst(rst), .bus_addr(addr2), .bus_we(we2), .bus_wdata(wdata2),
        .bus_rdata(rdata2), .pin_in(pin_in2), .pin_out(pin_out2), .pin_oe(pin_oe2), .irq(irq2)
    );

    // Behavioural reference for the default instance
    bit m_en[NP], m_dout[NP], m_dir[NP], m_mask[NP], m_stat[NP], m_edge[NP];
    bit s1[NP], s2[NP], s3[NP];

    always @(posedge clk) begin : model
        bit q[NP];
        int p;
        if (rst) begin
            for (int i = 0; i < NP; i++) begin
                m_en[i] = 0; m_dout[i] = 0; m_dir[i] = 1; m_mask[i] = 0;
                m_stat[i] = 0; m_edge[i] = 0; s1[i] = 0; s2[i] = 0; s3[i] = 0;
            end
        end else begin
            for (int i = 0; i < NP; i++)
                q[i] = m_en[i] && m_dir[i] &&
                       (m_edge[i] ? (s2[i] && !s3[i]) : (!s2[i] && s3[i]));
            if (we && addr[1:0] == 2'b00 && !addr[7]) begin
                for (int j = 0; j < 32; j++) begin
                    p = int'(addr[3:2]) * 32 + j;
                    if (p < NP) begin
                        case (addr[6:4])
                            3'd0: m_en[p]   = wdata[j];
                            3'd1: m_dout[p] = wdata[j];
                            3'd2: m_dir[p]  = wdata[j];
                            3'd4: m_mask[p] = wdata[j];
                            3'd5: if (!wdata[j]) m_stat[p] = 0;
                            3'd6: m_edge[p] = wdata[j];
                            default: ;
                        endcase
                    end
                end
            end
            for (int i = 0; i < NP; i++) begin
                if (q[i]) m_stat[i] = 1;
                s3[i] = s2[i]; s2[i] = s1[i]; s1[i] = pin_in[i];
            end
        end
    end

    function automatic logic [31:0] mrd(input logic [7:0] a);
        logic [31:0] r;
        int p;
        r = '0;
        if (a[1:0] == 2'b00 && !a[7]) begin
            for (int j = 0; j < 32; j++) begin
                p = int'(a[3:2]) * 32 + j;
                if (p < NP) begin
                    case (a[6:4])
                        3'd0: r[j] = m_en[p];
                        3'd1: r[j] = m_dout[p];
                        3'd2: r[j] = m_dir[p];
                        3'd3: r[j] = s2[p];
                        3'd4: r[j] = m_mask[p];
                        3'd5: r[j] = m_stat[p];
                        3'd6: r[j] = m_edge[p];
                        default: r[j] = 1'b0;
                    endcase
                end
            end
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        logic [NP-1:0] e_oe, e_out;
        logic e_irq;
        e_irq = 1'b0;
        for (int i = 0; i < NP; i++) begin
            e_oe[i]  = m_en[i] && !m_dir[i];
            e_out[i] = m_dout[i];
            if (m_stat[i] && !m_mask[i]) e_irq = 1'b1;
        end
        chk("R1 model rdata", 128'(rdata), 128'(mrd(addr)));
        chk("R3 model pin_oe", 128'(pin_oe), 128'(e_oe));
        chk("R3 model pin_out", 128'(pin_out), 128'(e_out));
        chk("R8 model irq", 128'(irq), 128'(e_irq));
    endtask

    task automatic tick();
        @(negedge clk);
        if (!rst) cmp_model();
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wr(input int bank, input int w, input logic [31:0] d);
        addr = 8'(bank * 16 + w * 4); we = 1'b1; wdata = d;
        tick();
        we = 1'b0;
    endtask

    task automatic rd(input string tag, input int bank, input int w, input logic [31:0] exp);
        addr = 8'(bank * 16 + w * 4);
        #1;
        chk(tag, 128'(rdata), 128'(exp));
    endtask

    task automatic wr2(input int bank, input int w, input logic [31:0] d);
        addr2 = 8'(bank * 8 + w * 4); we2 = 1'b1; wdata2 = d;
        tick();
        we2 = 1'b0;
    endtask

    task automatic rd2(input string tag, input int bank, input int w, input logic [31:0] exp);
        addr2 = 8'(bank * 8 + w * 4);
        #1;
        chk(tag, 128'(rdata2), 128'(exp));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        addr = '0; we = 1'b0; wdata = '0; pin_in = '0;
        addr2 = '0; we2 = 1'b0; wdata2 = '0; pin_in2 = '0;
        ticks(4);
        // R2 reset values, sampled while reset is held
        rd("R2 dir word0", 2, 0, 32'hFFFF_FFFF);
        rd("R2 dir last word", 2, 3, 32'h0000_003F);
        rd("R2 enable word0", 0, 0, 32'h0);
        chk("R2 irq", 128'(irq), 128'(0));
        chk("R2 pin_oe", 128'(pin_oe), 128'(0));
        rst = 1'b0;
        tick();

        // R1 / R3 addressing and output drive
        wr(1, 1, 32'hA5A5_0001);
        wr(0, 1, 32'hFFFF_FFFF);
        wr(2, 1, 32'h0);
        chk("R3 pin_oe word1", 128'(pin_oe[63:32]), 128'(32'hFFFF_FFFF));
        chk("R1 pin_out pin32", 128'(pin_out[32]), 128'(1));
        chk("R1 pin_out word1", 128'(pin_out[63:32]), 128'(32'hA5A5_0001));
        rd("R1 dout readback", 1, 1, 32'hA5A5_0001);
        addr = 8'h15; #1; chk("R1 misaligned read", 128'(rdata), 128'(0));
        addr = 8'h94; #1; chk("R1 upper bit read", 128'(rdata), 128'(0));
        addr = 8'h70; #1; chk("R1 bank7 read", 128'(rdata), 128'(0));

        // R10 input bank is read-only
        wr(3, 0, 32'hFFFF_FFFF);
        rd("R10 level after write", 3, 0, 32'h0);

        // R4 sync latency
        rd("R4 level idle", 3, 0, 32'h0);
        pin_in[5] = 1'b1;
        tick(); rd("R4 level after 1 edge", 3, 0, 32'h0);
        tick(); rd("R4 level after 2 edges", 3, 0, 32'h20);
        ticks(2);
        rd("R6 disabled pin no status", 5, 0, 32'h0);

        // R5 rising select
        wr(0, 0, 32'hFFFF_FFFF);
        wr(6, 0, 32'h20);
        pin_in[5] = 1'b0;
        ticks(4);
        rd("R5 falling ignored in rise mode", 5, 0, 32'h0);
        pin_in[5] = 1'b1;
        ticks(2); rd("R5 status not yet", 5, 0, 32'h0);
        tick();   rd("R5 rising sets status", 5, 0, 32'h20);
        chk("R8 irq on pending", 128'(irq), 128'(1));

        // R8 masking
        wr(4, 0, 32'h20);
        chk("R8 irq masked", 128'(irq), 128'(0));
        rd("R8 status kept while masked", 5, 0, 32'h20);
        wr(4, 0, 32'h0);
        chk("R8 irq unmasked", 128'(irq), 128'(1));

        // R7 clear semantics
        wr(5, 0, 32'hFFFF_FFFF);
        rd("R7 write ones keeps", 5, 0, 32'h20);
        wr(5, 0, ~32'h20);
        rd("R7 write zero clears", 5, 0, 32'h0);
        chk("R7 irq after clear", 128'(irq), 128'(0));

        // R5 falling select
        wr(6, 0, 32'h0);
        pin_in[5] = 1'b0;
        ticks(3);
        rd("R5 falling sets status", 5, 0, 32'h20);
        wr(5, 0, 32'h0);
        rd("R7 cleared", 5, 0, 32'h0);

        // R7 set wins over same-edge clear
        pin_in[5] = 1'b1;
        ticks(4);
        rd("R5 rising ignored in fall mode", 5, 0, 32'h0);
        pin_in[5] = 1'b0;
        ticks(2);
        wr(5, 0, 32'h0);
        rd("R7 set wins", 5, 0, 32'h20);
        wr(5, 0, 32'h0);
        rd("R7 cleared again", 5, 0, 32'h0);

        // R6 output pin and disabled pin
        pin_in[40] = 1'b1; pin_in[70] = 1'b1;
        ticks(3);
        pin_in[40] = 1'b0; pin_in[70] = 1'b0;
        ticks(4);
        rd("R6 output pin no status", 5, 1, 32'h0);
        rd("R6 disabled input no status", 5, 2, 32'h0);

        // R9 unused bits of last word
        wr(0, 3, 32'hFFFF_FFFF);
        rd("R9 enable last word", 0, 3, 32'h3F);
        wr(4, 3, 32'hFFFF_FFFF);
        rd("R9 mask last word", 4, 3, 32'h3F);
        wr(4, 3, 32'h0);
        wr(6, 3, 32'hFFFF_FFFF);
        rd("R9 edge last word", 6, 3, 32'h3F);
        wr(1, 3, 32'hFFFF_FFFF);
        rd("R9 dout last word", 1, 3, 32'h3F);
        pin_in[101] = 1'b1;
        ticks(3);
        rd("R9 status last word", 5, 3, 32'h20);
        chk("R8 irq from last word", 128'(irq), 128'(1));
        wr(5, 3, 32'h0);
        rd("R9 status cleared", 5, 3, 32'h0);

        // R12 no enable bank
        rd2("R12 enable reads ones w0", 0, 0, 32'hFFFF_FFFF);
        rd2("R12 enable reads ones w1", 0, 1, 32'h0000_00FF);
        wr2(0, 0, 32'h0);
        rd2("R12 enable write ignored", 0, 0, 32'hFFFF_FFFF);
        wr2(2, 0, 32'h0);
        chk("R12 outputs enabled", 128'(pin_oe2[31:0]), 128'(32'hFFFF_FFFF));

        // R11 level mode
        wr2(6, 1, 32'hFF);
        rd2("R11 edge bank reads zero", 6, 1, 32'h0);
        pin_in2[35] = 1'b1;
        ticks(2); rd2("R11 status not yet", 5, 1, 32'h0);
        tick();   rd2("R11 high level sets", 5, 1, 32'h08);
        chk("R11 irq", 128'(irq2), 128'(1));
        wr2(5, 1, 32'h0);
        rd2("R11 clear while high re-sets", 5, 1, 32'h08);
        pin_in2[35] = 1'b0;
        ticks(2);
        wr2(5, 1, 32'h0);
        rd2("R11 clear after low", 5, 1, 32'h0);
        chk("R11 irq cleared", 128'(irq2), 128'(0));

        ticks(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule